// File: doc/BRIEF.md
# Serial Link Startup and Recovery Controller

This block is the link-level state machine of a point-to-point serial link. After reset it walks the link through a timed recovery phase and an idle ready phase. Once it is allowed to start, it runs a handshake: the transmitter first sends NULL characters, then flow-control tokens, and only after both sides have shown they are alive does it enable full data transfer. Any protocol fault tears the link down and restarts the recovery sequence.

The receive decoder reports events to the block as single-cycle pulses: NULL seen, flow-control token seen, other character seen, and disconnect, parity, escape and credit errors. Three start controls set when the link may leave the ready phase: an explicit start, a start on the first received NULL, and a disable that overrides both. All phase durations are counted in system-clock cycles, computed from the clock frequency parameter. The figures below assume the default 200 MHz: 1280 cycles for 6.4 µs and 2560 cycles for 12.8 µs.

Top module: `link_init_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, every status output, transmitter enable and error flag is 0.
- R2: After reset the block stays 1280 cycles in recovery and 2560 cycles in wait, then enters ready. With start_i held high, started_o rises exactly 3841 clock edges after reset release. Every fault exit repeats the same 3841-edge delay before started_o rises again.
- R3: In ready, start_i leads to started on the next edge. With start_i and auto_start_i both low, the block stays in ready and all outputs stay 0.
- R4: In ready with auto_start_i high, a NULL pulse leads to started. A NULL is ignored while auto_start_i is low, and auto_start_i alone does nothing.
- R5: disable_i keeps the block in ready even while start_i is high. Asserted in run, it drops the link to recovery without raising any error flag.
- R6: In started, tx_en_o=1, tx_fct_o=0 and tx_data_o=0, so only NULLs are sent. A NULL pulse moves the block to connecting.
- R7: If no NULL arrives within 2560 cycles of entering started, the block returns to recovery. started_o is high for 2560 edges and low after the 2560th edge.
- R8: In connecting, tx_en_o=1, tx_fct_o=1 and tx_data_o=0. A flow-control token pulse moves the block to run, where all three enables are 1.
- R9: In connecting, any other character, any error, or a 2560-cycle timeout returns the block to recovery. An error that arrives in the same cycle as the token wins over it.
- R10: In run, a disconnect, parity or escape error returns the block to recovery and raises err_disc_o, err_par_o or err_esc_o for exactly one cycle. The flag is raised even when disable_i is asserted in the same cycle.
- R11: In run, a credit error returns the block to recovery and raises err_cred_o for exactly one cycle.
- R12: The error flags are raised only when the link leaves run. Errors seen in started or connecting cause recovery but raise no flag.
- R13: In wait, a received character returns the block to recovery, which restarts the full 3841-edge startup delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Leave ready unconditionally |
| auto_start_i | input | 1 | Leave ready on the first received NULL |
| disable_i | input | 1 | Block start and drop a live link |
| rx_null_i | input | 1 | NULL received pulse |
| rx_fct_i | input | 1 | Flow-control token received pulse |
| rx_char_i | input | 1 | Other (data/control) character received pulse |
| disc_err_i | input | 1 | Disconnect detected pulse |
| par_err_i | input | 1 | Parity error pulse |
| esc_err_i | input | 1 | Escape sequence error pulse |
| cred_err_i | input | 1 | Credit error pulse |
| started_o | output | 1 | In started phase |
| connecting_o | output | 1 | In connecting phase |
| running_o | output | 1 | In run phase |
| tx_en_o | output | 1 | Transmitter on (NULLs allowed) |
| tx_fct_o | output | 1 | Flow-control tokens allowed |
| tx_data_o | output | 1 | Data, packet-end and time characters allowed |
| err_disc_o | output | 1 | Disconnect flag, one-cycle pulse |
| err_par_o | output | 1 | Parity flag, one-cycle pulse |
| err_esc_o | output | 1 | Escape flag, one-cycle pulse |
| err_cred_o | output | 1 | Credit flag, one-cycle pulse |

## Verification
Two pairs of events can land in the same cycle. The first pair is a teardown request from disable_i and a disconnect error while in run. The second is a token that would complete the handshake and an escape error while in connecting. The bench pulses both inputs of each pair on the same edge. In the first case it expects recovery together with the disconnect flag. In the second it expects recovery with no flag and no visit to run. The bench predicts each outcome as a timed output vector and then confirms it with the exact reconnect time that follows.

// File: rtl/link_init_pkg.sv
package link_init_pkg;

  typedef enum logic [2:0] {
    ST_RECOVER  = 3'd0,
    ST_WAIT     = 3'd1,
    ST_READY    = 3'd2,
    ST_STARTED  = 3'd3,
    ST_CONNECT  = 3'd4,
    ST_RUN      = 3'd5
  } link_state_e;

  typedef struct packed {
    logic nul;
    logic fct;
    logic chr;
    logic disc;
    logic par;
    logic esc;
    logic cred;
  } rx_ev_t;

  localparam int unsigned ERR_N = 4;

  // cycles for a duration in tenths of a microsecond
  function automatic int unsigned cyc_for(input int unsigned clk_hz, input int unsigned tenth_us);
    int unsigned mhz;
    int unsigned c;
    mhz = clk_hz / 1_000_000;
    c = (mhz * tenth_us) / 10;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/link_phase_timer.sv
module link_phase_timer #(
  parameter int unsigned N_LIM = 3,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned LIMITS [N_LIM] = '{1, 1, 1}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [N_LIM-1:0] hit_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < N_LIM; g++) begin : g_cmp
    assign hit_o[g] = (cnt_q == CNT_W'(LIMITS[g] - 1));
  end

endmodule

// File: rtl/link_state_fsm.sv
module link_state_fsm
  import link_init_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        auto_start_i,
  input  logic        disable_i,
  input  rx_ev_t      ev_i,
  input  logic        recover_done_i,
  input  logic        wait_done_i,
  input  logic        timeout_i,
  output link_state_e state_o,
  output logic        restart_o
);

  link_state_e state_q, state_d;
  logic        err_any, bad_char;

  assign err_any  = ev_i.disc | ev_i.par | ev_i.esc | ev_i.cred;
  assign bad_char = ev_i.fct | ev_i.chr;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RECOVER: if (recover_done_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (err_any || bad_char) state_d = ST_RECOVER;
        else if (wait_done_i)    state_d = ST_READY;
      end
      ST_READY: begin
        if (err_any || bad_char) state_d = ST_RECOVER;
        else if (!disable_i && (start_i || (auto_start_i && ev_i.nul)))
          state_d = ST_STARTED;
      end
      ST_STARTED: begin
        if (disable_i || err_any || bad_char || timeout_i) state_d = ST_RECOVER;
        else if (ev_i.nul)                                 state_d = ST_CONNECT;
      end
      ST_CONNECT: begin
        // error or stray character beats a token in the same cycle
        if (disable_i || err_any || ev_i.chr || timeout_i) state_d = ST_RECOVER;
        else if (ev_i.fct)                                 state_d = ST_RUN;
      end
      ST_RUN: if (disable_i || err_any) state_d = ST_RECOVER;
      default: state_d = ST_RECOVER;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RECOVER;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign restart_o = (state_d != state_q);

  logic rx_fct_w;
  assign rx_fct_w = ev_i.fct;

  p_ready_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY && start_i && !disable_i && !err_any && !bad_char)
    |=> state_q == ST_STARTED);

  p_disable_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY && disable_i) |=> state_q != ST_STARTED);

  p_run_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) != ST_RUN)
    |-> ($past(state_q) == ST_CONNECT && $past(rx_fct_w)));

  p_run_err_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && err_any) |=> state_q == ST_RECOVER);

  p_start_timeout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STARTED && timeout_i) |=> state_q == ST_RECOVER);

  p_wait_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && $past(state_q) == ST_RECOVER) |-> $past(recover_done_i));

endmodule

// File: rtl/link_err_report.sv
module link_err_report
  import link_init_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_run_i,
  input  logic [ERR_N-1:0] err_i,
  output logic [ERR_N-1:0] flag_o
);

  logic [ERR_N-1:0] flag_q;

  for (genvar g = 0; g < ERR_N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= in_run_i & err_i[g];
    end
  end

  assign flag_o = flag_q;

  p_flag_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_q) |=> !(|flag_q));

  // R11 credit flag shares this rule
  p_flag_left_run_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_q) |-> !in_run_i);

endmodule

// File: rtl/link_init_ctrl.sv
module link_init_ctrl
  import link_init_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic auto_start_i,
  input  logic disable_i,
  input  logic rx_null_i,
  input  logic rx_fct_i,
  input  logic rx_char_i,
  input  logic disc_err_i,
  input  logic par_err_i,
  input  logic esc_err_i,
  input  logic cred_err_i,
  output logic started_o,
  output logic connecting_o,
  output logic running_o,
  output logic tx_en_o,
  output logic tx_fct_o,
  output logic tx_data_o,
  output logic err_disc_o,
  output logic err_par_o,
  output logic err_esc_o,
  output logic err_cred_o
);

  localparam int unsigned RECOVER_CYC = cyc_for(SYS_CLK_HZ, 64);
  localparam int unsigned WAIT_CYC    = cyc_for(SYS_CLK_HZ, 128);
  localparam int unsigned TIMEOUT_CYC = cyc_for(SYS_CLK_HZ, 128);
  localparam int unsigned MAX_A       = (RECOVER_CYC > WAIT_CYC) ? RECOVER_CYC : WAIT_CYC;
  localparam int unsigned MAX_CYC     = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
  localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1);
  localparam int unsigned N_LIM       = 3;
  localparam int unsigned LIM_TAB [N_LIM] = '{RECOVER_CYC, WAIT_CYC, TIMEOUT_CYC};

  rx_ev_t           ev;
  link_state_e      state;
  logic             restart;
  logic [N_LIM-1:0] hit;
  logic [ERR_N-1:0] err_vec, flag_vec;

  assign ev = '{nul: rx_null_i, fct: rx_fct_i, chr: rx_char_i,
                disc: disc_err_i, par: par_err_i, esc: esc_err_i, cred: cred_err_i};

  link_phase_timer #(
    .N_LIM  (N_LIM),
    .CNT_W  (CNT_W),
    .LIMITS (LIM_TAB)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .hit_o     (hit)
  );

  link_state_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .auto_start_i   (auto_start_i),
    .disable_i      (disable_i),
    .ev_i           (ev),
    .recover_done_i (hit[0]),
    .wait_done_i    (hit[1]),
    .timeout_i      (hit[2]),
    .state_o        (state),
    .restart_o      (restart)
  );

  assign err_vec = {disc_err_i, par_err_i, esc_err_i, cred_err_i};

  link_err_report u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_run_i (state == ST_RUN),
    .err_i    (err_vec),
    .flag_o   (flag_vec)
  );

  assign started_o    = (state == ST_STARTED);
  assign connecting_o = (state == ST_CONNECT);
  assign running_o    = (state == ST_RUN);
  assign tx_en_o      = started_o | connecting_o | running_o;
  assign tx_fct_o     = connecting_o | running_o;
  assign tx_data_o    = running_o;
  assign {err_disc_o, err_par_o, err_esc_o, err_cred_o} = flag_vec;

endmodule

// File: tb/tb_link_init_ctrl.sv
`timescale 1ns/1ps
module tb_link_init_ctrl;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, auto_start_i = 0, disable_i = 0;
  logic rx_null_i = 0, rx_fct_i = 0, rx_char_i = 0;
  logic disc_err_i = 0, par_err_i = 0, esc_err_i = 0, cred_err_i = 0;
  logic started_o, connecting_o, running_o, tx_en_o, tx_fct_o, tx_data_o;
  logic err_disc_o, err_par_o, err_esc_o, err_cred_o;

  always #2.5 clk = ~clk;

  link_init_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .auto_start_i(auto_start_i),
    .disable_i(disable_i), .rx_null_i(rx_null_i), .rx_fct_i(rx_fct_i), .rx_char_i(rx_char_i),
    .disc_err_i(disc_err_i), .par_err_i(par_err_i), .esc_err_i(esc_err_i), .cred_err_i(cred_err_i),
    .started_o(started_o), .connecting_o(connecting_o), .running_o(running_o),
    .tx_en_o(tx_en_o), .tx_fct_o(tx_fct_o), .tx_data_o(tx_data_o),
    .err_disc_o(err_disc_o), .err_par_o(err_par_o), .err_esc_o(err_esc_o), .err_cred_o(err_cred_o)
  );

  // obs = {started, connecting, running, tx_en, tx_fct, tx_data, disc, par, esc, cred}
  localparam logic [9:0] O_IDLE = 10'b0000000000;
  localparam logic [9:0] O_STA  = 10'b1001000000;
  localparam logic [9:0] O_CON  = 10'b0101100000;
  localparam logic [9:0] O_RUN  = 10'b0011110000;
  localparam logic [6:0] E_NUL = 7'b1000000, E_FCT = 7'b0100000, E_CHR = 7'b0010000;
  localparam logic [6:0] E_DSC = 7'b0001000, E_PAR = 7'b0000100, E_ESC = 7'b0000010;
  localparam logic [6:0] E_CRD = 7'b0000001;
  localparam int RECON = 3841;
  localparam int TMO   = 2560;

  typedef struct {
    int unsigned cyc;
    logic [9:0]  val;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [9:0]  obs;

  assign obs = {started_o, connecting_o, running_o, tx_en_o, tx_fct_o, tx_data_o,
                err_disc_o, err_par_o, err_esc_o, err_cred_o};

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      n_chk++;
      if (sb_q[0].cyc < cyc) begin
        n_fail++;
        $display("FAIL %s: check at cycle %0d missed (actual n/a, expected %b)",
                 sb_q[0].tag, sb_q[0].cyc, sb_q[0].val);
      end else if (obs !== sb_q[0].val) begin
        n_fail++;
        $display("FAIL %s: cycle %0d actual %b expected %b", sb_q[0].tag, cyc, obs, sb_q[0].val);
      end
      void'(sb_q.pop_front());
    end
  end

  task automatic expect_in(input int k, input logic [9:0] v, input string tag);
    exp_t e;
    e.cyc = cyc + k;
    e.val = v;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_ev(input logic [6:0] v);
    {rx_null_i, rx_fct_i, rx_char_i, disc_err_i, par_err_i, esc_err_i, cred_err_i} = v;
    @(negedge clk);
    {rx_null_i, rx_fct_i, rx_char_i, disc_err_i, par_err_i, esc_err_i, cred_err_i} = '0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    expect_in(1, O_IDLE, "R1");
    tick(3);
    rst_ni = 1'b1;
  endtask

  // called right after entry into recovery, start_i high
  task automatic reconnect(input string tag);
    expect_in(RECON - 1, O_IDLE, tag);
    expect_in(RECON, O_STA, tag);
    tick(RECON);
  endtask

  task automatic go_run();
    expect_in(1, O_CON, "R6");
    drive_ev(E_NUL);
    expect_in(1, O_RUN, "R8");
    drive_ev(E_FCT);
  endtask

  task automatic run_err(input logic [6:0] ev, input logic [9:0] flag, input string tag);
    expect_in(1, flag, tag);
    expect_in(2, O_IDLE, tag);
    drive_ev(ev);
    reconnect(tag);
  endtask

  initial begin
    // startup timing, handshake, run errors
    start_i = 1;
    apply_reset();
    expect_in(1, O_IDLE, "R1");
    reconnect("R2");
    go_run();
    run_err(E_DSC, 10'b0000001000, "R10");
    go_run();
    run_err(E_PAR, 10'b0000000100, "R10");
    go_run();
    run_err(E_ESC, 10'b0000000010, "R10");
    go_run();
    run_err(E_CRD, 10'b0000000001, "R11");
    go_run();
    // disable and disconnect in the same cycle
    disable_i = 1;
    expect_in(1, 10'b0000001000, "R10");
    drive_ev(E_DSC);
    expect_in(3899, O_IDLE, "R5");
    tick(3899);
    expect_in(1, O_STA, "R5");
    disable_i = 0;
    tick(1);
    go_run();
    expect_in(1, O_IDLE, "R5");
    expect_in(2, O_IDLE, "R5");
    disable_i = 1;
    tick(1);
    disable_i = 0;

    // no start controls, then auto start
    start_i = 0;
    auto_start_i = 0;
    apply_reset();
    expect_in(4000, O_IDLE, "R3");
    tick(4000);
    expect_in(1, O_IDLE, "R4");
    drive_ev(E_NUL);
    auto_start_i = 1;
    expect_in(50, O_IDLE, "R4");
    tick(50);
    expect_in(1, O_STA, "R4");
    drive_ev(E_NUL);
    auto_start_i = 0;

    // started timeout
    expect_in(TMO - 1, O_STA, "R7");
    expect_in(TMO, O_IDLE, "R7");
    tick(TMO);
    start_i = 1;
    reconnect("R7");

    // error in started: no flag
    expect_in(1, O_IDLE, "R12");
    expect_in(2, O_IDLE, "R12");
    drive_ev(E_PAR);
    reconnect("R12");

    // connecting faults
    expect_in(1, O_CON, "R6");
    drive_ev(E_NUL);
    expect_in(1, O_IDLE, "R9");
    drive_ev(E_CHR);
    reconnect("R9");
    expect_in(1, O_CON, "R6");
    drive_ev(E_NUL);
    expect_in(1, O_IDLE, "R9");
    expect_in(2, O_IDLE, "R12");
    drive_ev(E_FCT | E_ESC);
    reconnect("R9");
    expect_in(1, O_CON, "R6");
    drive_ev(E_NUL);
    expect_in(TMO - 1, O_CON, "R9");
    expect_in(TMO, O_IDLE, "R9");
    tick(TMO);

    // character during wait
    apply_reset();
    tick(1290);
    expect_in(1, O_IDLE, "R13");
    drive_ev(E_CHR);
    reconnect("R13");

    tick(3);
    done = 1;
  end

  initial begin : watchdog
    int k;
    for (k = 0; k < 200000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
    end
    if (sb_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending, expected 0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule